// File: doc/BRIEF.md
# Serial PHY Management Frame Master

This block runs single register transactions against an Ethernet PHY over a two-wire management bus. The bus has a clock that this block drives and a shared data line. Host logic gives a PHY address, a register address and, for writes, a 16-bit word. It then raises one of three request lines: write, read or initialise. The block divides the system clock down to the bus rate, shifts out a 32-bit frame most significant bit first, and releases the data line where the PHY is to answer. On a read it collects the returned word.

The data line is exposed as a pad-ready triple: an output value, an output enable and an input. A released line is assumed to be pulled high outside the block. Busy stays high from the cycle after a request is taken until the bus is back at rest. A supervising controller waits for busy to fall before it issues the next request.

The initialise request puts a run of 32 one bits on the bus with the data line released. The PHY uses this to synchronise, and no frame follows it.

Top module: `phy_mgmt_master`

## Requirements
- R1: Out of reset, and whenever busy is low, the block rests with `mgmt_clk` high, `md_oe` low and `md_out` high. `rd_word` resets to zero.
- R2: One bus half period lasts `div_count` system clocks, and a `div_count` of 0 acts as 1. The value is latched when a request is taken, so later changes to `div_count` do not affect the running transfer. Each bit cell is a low half followed by a high half.
- R3: A write frame is 32 bits, sent most significant bit first: start 01, opcode 01, 5-bit PHY address, 5-bit register address, turnaround 10, then the 16 bits of `wr_word`. All 32 bits are driven, and `md_out` and `md_oe` change only while `mgmt_clk` is low.
- R4: A read frame carries start 01, opcode 10 and the two addresses, and the block drives those 14 bits. It releases the data line for the 2-bit turnaround and for the 16 data bits. `md_in` is sampled on each rising bus clock edge of the data bits, and the first bit sampled becomes bit 15 of the result.
- R5: An initialise request produces 32 bus clock cycles with the data line released and `md_out` high throughout.
- R6: After the high half of the last bit, the clock goes low with the data line released for one half period. Then the clock returns high and busy falls. Busy is high for exactly 65 half periods, counted from the clock edge at which the request is taken.
- R7: A request is taken only on a rising edge of its input while busy is low. Edges that arrive during a transfer are dropped, and a request held high does not start a second transfer.
- R8: When several request inputs rise in the same cycle, initialise wins over read, and read wins over write.
- R9: `rd_word` changes only in the cycle busy falls at the end of a read. Writes and initialise sequences leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| div_count | input | 16 | Half period of the bus clock in system clocks (0 acts as 1) |
| wr_req | input | 1 | Write request, taken on a rising edge |
| rd_req | input | 1 | Read request, taken on a rising edge |
| init_req | input | 1 | Initialise request, taken on a rising edge |
| phy_sel | input | 5 | PHY address placed in the frame |
| reg_sel | input | 5 | Register address placed in the frame |
| wr_word | input | 16 | Data sent by a write |
| rd_word | output | 16 | Data returned by the last read |
| busy | output | 1 | High while a transfer is in progress |
| mgmt_clk | output | 1 | Bus clock |
| md_out | output | 1 | Data line output value |
| md_oe | output | 1 | Data line output enable (high = drive) |
| md_in | input | 1 | Data line input from the pad |

## Verification
The assertions assume three things about the inputs. The request inputs are synchronous to `clk` and are low while reset is applied. `md_in` is settled at the system clock edge where the bus clock rises. Addresses and write data stay stable for the cycle in which a request is taken. The stimulus changes every input only on the falling system clock edge, and it holds the request levels low during reset. The modelled PHY presents each read bit during the low half. It then drives the inverted bit through the high half, so only sampling at the rising bus clock edge produces the expected word.

// File: rtl/mgmt_pkg.sv
// Shared types and fixed code points for the management frame master.
// Assumes the frame layout start/opcode/addresses/turnaround/data is fixed.
package mgmt_pkg;

    typedef enum logic [1:0] {
        XF_WRITE = 2'd0,
        XF_READ  = 2'd1,
        XF_INIT  = 2'd2
    } xfer_kind_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_STOP  = 2'd2
    } eng_state_t;

    localparam logic [1:0] START_CODE = 2'b01;
    localparam logic [1:0] OPC_WRITE  = 2'b01;
    localparam logic [1:0] OPC_READ   = 2'b10;
    localparam logic [1:0] TA_DRIVEN  = 2'b10;
    localparam logic [1:0] TA_RELEASE = 2'b11;

endpackage

// File: rtl/mgmt_req_arbiter.sv
// Detects rising edges on the three request inputs and issues a single
// start pulse while the engine is idle. Priority is init, then read, then write.
// Assumes the requests are synchronous to clk.
module mgmt_req_arbiter
    import mgmt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_req,
    input  logic       rd_req,
    input  logic       init_req,
    input  logic       idle,
    output logic       start,
    output xfer_kind_t kind
);

    logic [2:0] prev_q;
    logic [2:0] rise;

    // Remember last request levels; edges seen while busy are consumed here.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 3'b000;
        else        prev_q <= {init_req, rd_req, wr_req};
    end

    assign rise = {init_req, rd_req, wr_req} & ~prev_q;

    // Pick the winning request by fixed priority.
    always_comb begin
        if (rise[2])      kind = XF_INIT;
        else if (rise[1]) kind = XF_READ;
        else              kind = XF_WRITE;
    end

    assign start = idle && (rise != 3'b000);

    // R7: a taken request makes the engine busy, so no back-to-back start.
    assert_single_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !start);

endmodule

// File: rtl/mgmt_half_timer.sv
// Produces a one-cycle tick at the end of each bus half period. The half
// length is latched on load; zero is promoted to one. Assumes load only
// occurs while run is low.
module mgmt_half_timer #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DIV_W-1:0] div_in,
    input  logic             run,
    output logic             tick
);

    logic [DIV_W-1:0] half_q;
    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q == half_q - DIV_W'(1));

    // Latch the half length at load and count within each half period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_q <= DIV_W'(1);
            cnt_q  <= '0;
        end else if (load) begin
            half_q <= (div_in == '0) ? DIV_W'(1) : div_in;
            cnt_q  <= '0;
        end else if (!run || tick) begin
            cnt_q  <= '0;
        end else begin
            cnt_q  <= cnt_q + DIV_W'(1);
        end
    end

    // R2: the counter never reaches the latched half length.
    assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (half_q != '0) && (cnt_q < half_q));

endmodule

// File: rtl/mgmt_frame_engine.sv
// Serialises one management frame or the initialise run, drives the bus
// clock, controls the data line enable and collects read data. The bus clock
// is low for the first half of each bit and high for the second. Assumes a
// tick from the half timer marks each half-period boundary.
module mgmt_frame_engine
    import mgmt_pkg::*;
#(
    parameter int ADDR_W   = 5,
    parameter int DATA_W   = 16,
    parameter int PRE_BITS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  xfer_kind_t        kind,
    input  logic [ADDR_W-1:0] phy_sel,
    input  logic [ADDR_W-1:0] reg_sel,
    input  logic [DATA_W-1:0] wr_word,
    input  logic              tick,
    input  logic              md_in,
    output logic              busy,
    output logic              mgmt_clk,
    output logic              md_out,
    output logic              md_oe,
    output logic [DATA_W-1:0] rd_word
);

    localparam int HDR_BITS   = 4 + 2 * ADDR_W;
    localparam int DAT_START  = HDR_BITS + 2;
    localparam int FRAME_BITS = DAT_START + DATA_W;
    localparam int SH_W       = (FRAME_BITS > PRE_BITS) ? FRAME_BITS : PRE_BITS;
    localparam int IDX_W      = $clog2(SH_W + 1);

    eng_state_t        state;
    xfer_kind_t        kind_q;
    logic              phase_hi;
    logic [IDX_W-1:0]  bit_idx;
    logic [IDX_W-1:0]  last_idx;
    logic [SH_W-1:0]   tx_q;
    logic [SH_W-1:0]   load_vec;
    logic [FRAME_BITS-1:0] frame;
    logic [DATA_W-1:0] rx_q;

    // Assemble the outgoing frame from the request fields.
    always_comb begin
        frame = {START_CODE,
                 (kind == XF_READ) ? OPC_READ : OPC_WRITE,
                 phy_sel, reg_sel,
                 (kind == XF_READ) ? TA_RELEASE : TA_DRIVEN,
                 (kind == XF_READ) ? {DATA_W{1'b0}} : wr_word};
        if (kind == XF_INIT) load_vec = '1;
        else                 load_vec = SH_W'(frame) << (SH_W - FRAME_BITS);
    end

    assign last_idx = (kind_q == XF_INIT) ? IDX_W'(PRE_BITS - 1) : IDX_W'(FRAME_BITS - 1);

    // Sequence bits and half periods; capture read data on bus clock rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            kind_q   <= XF_WRITE;
            phase_hi <= 1'b0;
            bit_idx  <= '0;
            tx_q     <= '0;
            rx_q     <= '0;
            rd_word  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        state    <= ST_SHIFT;
                        kind_q   <= kind;
                        phase_hi <= 1'b0;
                        bit_idx  <= '0;
                        tx_q     <= load_vec;
                    end
                end
                ST_SHIFT: begin
                    if (tick && !phase_hi) begin
                        phase_hi <= 1'b1;
                        if (kind_q == XF_READ && bit_idx >= IDX_W'(DAT_START))
                            rx_q <= {rx_q[DATA_W-2:0], md_in};
                    end else if (tick) begin
                        phase_hi <= 1'b0;
                        if (bit_idx == last_idx) begin
                            state <= ST_STOP;
                        end else begin
                            bit_idx <= bit_idx + IDX_W'(1);
                            tx_q    <= tx_q << 1;
                        end
                    end
                end
                ST_STOP: begin
                    if (tick) begin
                        state <= ST_IDLE;
                        if (kind_q == XF_READ) rd_word <= rx_q;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy     = (state != ST_IDLE);
    assign mgmt_clk = (state == ST_IDLE) || (state == ST_SHIFT && phase_hi);
    assign md_oe    = (state == ST_SHIFT) &&
                      ((kind_q == XF_WRITE) ||
                       (kind_q == XF_READ && bit_idx < IDX_W'(HDR_BITS)));
    assign md_out   = md_oe ? tx_q[SH_W-1] : 1'b1;

    // R1: at rest the clock is high and the line is released.
    assert_idle_rest_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (mgmt_clk && !md_oe && md_out));

    // R3: the line changes only while the bus clock is low.
    assert_hold_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mgmt_clk && $past(mgmt_clk)) |-> ($stable(md_out) && $stable(md_oe)));

    // R5: an initialise run never drives the line.
    assert_init_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && kind_q == XF_INIT) |-> !md_oe);

    // R6: before busy falls, the clock was low with the line released.
    assert_stop_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(!mgmt_clk) && $past(!md_oe) && mgmt_clk));

    // R9: the read result only moves at the end of a read.
    assert_rdword_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_STOP || kind_q != XF_READ) |=> $stable(rd_word));

endmodule

// File: rtl/phy_mgmt_master.sv
// Top level of the serial PHY management frame master: request edge
// arbitration, half-period timer and frame engine. The data line is split
// into output value, output enable and input for the pad ring; a released
// line is assumed to be pulled high externally.
module phy_mgmt_master
    import mgmt_pkg::*;
#(
    parameter int DIV_W    = 16,
    parameter int ADDR_W   = 5,
    parameter int DATA_W   = 16,
    parameter int PRE_BITS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div_count,
    input  logic              wr_req,
    input  logic              rd_req,
    input  logic              init_req,
    input  logic [ADDR_W-1:0] phy_sel,
    input  logic [ADDR_W-1:0] reg_sel,
    input  logic [DATA_W-1:0] wr_word,
    output logic [DATA_W-1:0] rd_word,
    output logic              busy,
    output logic              mgmt_clk,
    output logic              md_out,
    output logic              md_oe,
    input  logic              md_in
);

    logic       start;
    logic       tick;
    xfer_kind_t kind;

    mgmt_req_arbiter u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_req   (wr_req),
        .rd_req   (rd_req),
        .init_req (init_req),
        .idle     (!busy),
        .start    (start),
        .kind     (kind)
    );

    mgmt_half_timer #(.DIV_W(DIV_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (start),
        .div_in (div_count),
        .run    (busy),
        .tick   (tick)
    );

    mgmt_frame_engine #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .PRE_BITS (PRE_BITS)
    ) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .kind     (kind),
        .phy_sel  (phy_sel),
        .reg_sel  (reg_sel),
        .wr_word  (wr_word),
        .tick     (tick),
        .md_in    (md_in),
        .busy     (busy),
        .mgmt_clk (mgmt_clk),
        .md_out   (md_out),
        .md_oe    (md_oe),
        .rd_word  (rd_word)
    );

endmodule

// File: tb/phy_mgmt_master_test.sv
`timescale 1ns/1ps
module phy_mgmt_master_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] div_count = 16'd2;
    logic        wr_req = 1'b0, rd_req = 1'b0, init_req = 1'b0;
    logic [4:0]  phy_sel = '0, reg_sel = '0;
    logic [15:0] wr_word = '0;
    logic [15:0] rd_word;
    logic        busy, mgmt_clk, md_out, md_oe;
    logic        md_in = 1'b1;

    always #2.5 clk = ~clk;

    phy_mgmt_master uut (
        .clk(clk), .rst_n(rst_n), .div_count(div_count),
        .wr_req(wr_req), .rd_req(rd_req), .init_req(init_req),
        .phy_sel(phy_sel), .reg_sel(reg_sel), .wr_word(wr_word),
        .rd_word(rd_word), .busy(busy), .mgmt_clk(mgmt_clk),
        .md_out(md_out), .md_oe(md_oe), .md_in(md_in)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    // Expected line contents as seen at each rising bus clock (released = 1).
    function automatic logic [31:0] line_frame(int k, logic [4:0] p, logic [4:0] g, logic [15:0] d);
        if (k == 2) return 32'hFFFF_FFFF;
        if (k == 1) return {2'b01, 2'b10, p, g, 18'h3FFFF};
        return {2'b01, 2'b01, p, g, 2'b10, d};
    endfunction

    // Behavioural reference: time since acceptance, latched half length.
    bit          m_active = 0;
    int          m_t = 0, m_half = 1, m_kind = 0;
    logic [31:0] m_frame = '0;
    logic [2:0]  m_prev = '0;
    logic [15:0] phy_word = '0;

    always @(posedge clk) begin
        logic [2:0] lv;
        logic [2:0] rs;
        lv = {init_req, rd_req, wr_req};
        rs = lv & ~m_prev;
        if (!rst_n) begin
            m_active = 0;
            lv = 3'b000;
        end else if (m_active) begin
            m_t++;
            if (m_t == 65 * m_half) m_active = 0;
        end else if (rs != 3'b000) begin
            m_active = 1;
            m_t      = 0;
            m_half   = (div_count == 0) ? 1 : int'(div_count);
            m_kind   = rs[2] ? 2 : (rs[1] ? 1 : 0);
            m_frame  = line_frame(m_kind, phy_sel, reg_sel, wr_word);
        end
        m_prev = lv;
    end

    // Per-cycle comparison, PHY model, and frame/busy collectors.
    int          busy_len = 0;
    int          oe_seen  = 0;
    logic [31:0] cap = '0;
    logic        mc_prev = 1'b1;

    always @(negedge clk) begin
        int seg, b;
        logic e_clk, e_oe, e_out;
        if (rst_n) begin
            e_clk = 1'b1; e_oe = 1'b0; e_out = 1'b1;
            seg = 0; b = 0;
            if (m_active) begin
                seg = m_t / m_half;
                b   = seg / 2;
                if (seg < 64) begin
                    e_clk = seg[0];
                    e_oe  = (m_kind == 0) || (m_kind == 1 && b < 14);
                    e_out = m_frame[31 - b];
                    if (!e_oe) e_out = 1'b1;
                end else begin
                    e_clk = 1'b0;
                end
            end
            check(busy == m_active, "R6 busy", {31'd0, busy}, {31'd0, m_active});
            check(mgmt_clk == e_clk, "R2 mgmt clock", {31'd0, mgmt_clk}, {31'd0, e_clk});
            check(md_oe == e_oe, "R3 data enable", {31'd0, md_oe}, {31'd0, e_oe});
            check(md_out == e_out, "R3 data value", {31'd0, md_out}, {31'd0, e_out});
            if (busy) busy_len++;
            if (md_oe) oe_seen++;
            if (mgmt_clk && !mc_prev && busy) cap = {cap[30:0], md_oe ? md_out : 1'b1};
            mc_prev = mgmt_clk;
            // PHY drives read data: true bit in low half, inverted in high half.
            if (m_active && m_kind == 1 && seg < 64 && b >= 16)
                md_in = seg[0] ? ~phy_word[31 - b] : phy_word[31 - b];
            else
                md_in = 1'b1;
        end
    end

    task automatic run(input logic w, input logic r, input logic i,
                       input logic [4:0] p, input logic [4:0] g,
                       input logic [15:0] d, input logic [15:0] dv, input logic [15:0] pw);
        int extra;
        @(negedge clk);
        phy_sel = p; reg_sel = g; wr_word = d; div_count = dv; phy_word = pw;
        busy_len = 0; oe_seen = 0; cap = '0;
        wr_req = w; rd_req = r; init_req = i;
        @(negedge clk);
        while (m_active) @(negedge clk);
        extra = 0;
        repeat (4) begin
            @(negedge clk);
            if (busy) extra++;
        end
        check(extra == 0, "R7 held request does not retrigger", extra, 0);
        wr_req = 0; rd_req = 0; init_req = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog R6 transfer never ended actual=%0d expected=%0d", busy, 0);
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(busy == 0 && mgmt_clk == 1 && md_oe == 0 && md_out == 1, "R1 reset rest",
              {busy, mgmt_clk, md_oe, md_out}, 4'b0101);
        check(rd_word == 16'h0, "R1 rd_word reset", rd_word, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R3 write with a read edge during the transfer (R7)
        fork
            run(1, 0, 0, 5'h11, 5'h05, 16'hA5C3, 16'd2, 16'h0);
            begin
                repeat (20) @(negedge clk);
                rd_req = 1;
                repeat (3) @(negedge clk);
                rd_req = 0;
            end
        join
        check(cap == line_frame(0, 5'h11, 5'h05, 16'hA5C3), "R3 write frame", cap, line_frame(0, 5'h11, 5'h05, 16'hA5C3));
        check(busy_len == 130, "R6 busy length half=2", busy_len, 130);
        check(rd_word == 16'h0, "R7 read edge during write ignored / R9", rd_word, 0);

        // R4 read, half=3
        run(0, 1, 0, 5'h03, 5'h1F, 16'hFFFF, 16'd3, 16'h5E71);
        check(rd_word == 16'h5E71, "R4 read data", rd_word, 16'h5E71);
        check(cap == line_frame(1, 5'h03, 5'h1F, 16'h0), "R4 read header and release", cap, line_frame(1, 5'h03, 5'h1F, 16'h0));
        check(busy_len == 195, "R2 busy length half=3", busy_len, 195);

        // R9 write leaves rd_word
        run(1, 0, 0, 5'h00, 5'h13, 16'h1234, 16'd1, 16'h0);
        check(rd_word == 16'h5E71, "R9 write keeps rd_word", rd_word, 16'h5E71);
        check(cap == line_frame(0, 5'h00, 5'h13, 16'h1234), "R3 write frame half=1", cap, line_frame(0, 5'h00, 5'h13, 16'h1234));

        // R5 init with div 0
        run(0, 0, 1, 5'h1A, 5'h0C, 16'h0, 16'd0, 16'h0);
        check(oe_seen == 0, "R5 init never drives", oe_seen, 0);
        check(cap == 32'hFFFF_FFFF, "R5 init all ones", cap, 32'hFFFF_FFFF);
        check(busy_len == 65, "R2 div zero acts as one", busy_len, 65);
        check(rd_word == 16'h5E71, "R9 init keeps rd_word", rd_word, 16'h5E71);

        // R2 divider change mid-transfer is ignored
        fork
            run(0, 1, 0, 5'h07, 5'h02, 16'h0, 16'd2, 16'hC00F);
            begin
                repeat (7) @(negedge clk);
                div_count = 16'd9;
            end
        join
        check(busy_len == 130, "R2 latched divider", busy_len, 130);
        check(rd_word == 16'hC00F, "R4 read data second", rd_word, 16'hC00F);

        // R8 priority: init over write
        run(1, 0, 1, 5'h01, 5'h01, 16'hFFFF, 16'd1, 16'h0);
        check(oe_seen == 0, "R8 init beats write", oe_seen, 0);
        // R8 priority: read over write
        run(1, 1, 0, 5'h02, 5'h04, 16'h0F0F, 16'd1, 16'h8001);
        check(rd_word == 16'h8001, "R8 read beats write", rd_word, 16'h8001);
        check(cap == line_frame(1, 5'h02, 5'h04, 16'h0), "R8 read frame chosen", cap, line_frame(1, 5'h02, 5'h04, 16'h0));

        repeat (5) @(negedge clk);
        check(busy == 0 && mgmt_clk == 1, "R1 rest after all", {busy, mgmt_clk}, 2'b01);
        finish_up();
    end

endmodule